// File: doc/BRIEF.md
# Eight-Lane Lockstep Shading Datapath

This block runs a short shading program over eight fragments at once. One sequencer holds a small program store and a program counter. Each cycle it issues one decoded instruction to eight arithmetic lanes, and all lanes execute it together. Every lane keeps its own register file, which is that fragment's private state. A bank of constants sits beside the lanes. When an instruction names a constant as its second operand, the single constant value is broadcast to all lanes.

Values are 16-bit signed fixed point with eight fraction bits, so 1.0 is 0x0100. There are four operations: multiply, multiply-add into the destination, clamp to the unit range, and move of a literal. Before a run, software-side logic loads the program store, the constant bank and each lane's input registers through simple write ports. It then pulses start with a program length. When the last instruction has written its results, a one-cycle done pulse marks the point where the eight four-word output records (registers 12 to 15 of each lane) are valid.

Top module: `shd_simd8_core`

## Requirements
- R1: After reset, busy and done are low, and every lane register, constant entry and program word is zero, so out_rec reads all zero.
- R2: A start sampled while idle, with run_len from 1 to IMEM_DEPTH, raises busy at that edge. Instructions 0 to run_len-1 then execute on the next run_len edges. done is high for exactly the one cycle after the last of those edges, and busy is low from that cycle on.
- R3: MUL (op code 0) writes floor(a*b / 256) to dst, saturated to the range -32768 to 32767.
- R4: MAD (op code 1) writes floor(a*b / 256) plus the old dst value to dst, saturated to the same range. The destination also serves as the accumulator.
- R5: CLMP (op code 2) writes to dst the first operand bounded below by 0 and above by 256 (1.0).
- R6: MOVI (op code 3) writes the 16-bit literal field to dst in every lane.
- R7: When the constant flag is 1, the second operand is constant-bank entry sb[2:0], and all lanes see the same value. When the flag is 0, the second operand is each lane's own register sb.
- R8: The instruction word is 31 bits: op [30:29], dst [28:25], sa [24:21], sb [20:17], constant flag [16], literal [15:0].
- R9: Register 12+k of lane L appears on out_rec[(4*L+k)*16 +: 16], for k from 0 to 3.
- R10: While busy, writes to lane registers, constants and the program store, and further start pulses, have no effect.
- R11: All lanes execute the same instruction in the same cycle, each on its own register contents, so lanes loaded with different data give independently correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run of run_len instructions |
| run_len | input | 5 | Number of instructions to execute (1 to 16) |
| im_we | input | 1 | Program store write enable |
| im_addr | input | 4 | Program store write address |
| im_data | input | 31 | Instruction word to store |
| cb_we | input | 1 | Constant bank write enable |
| cb_addr | input | 3 | Constant bank write address |
| cb_data | input | 16 | Constant value |
| ctx_we | input | 1 | Lane register write enable |
| ctx_lane | input | 3 | Lane selected for the register write |
| ctx_reg | input | 4 | Register index within the lane |
| ctx_data | input | 16 | Register value |
| busy | output | 1 | A program run is in progress |
| done | output | 1 | One-cycle pulse: output records valid |
| out_rec | output | 512 | Output records of all lanes, registers 12 to 15 |

## Verification
The bench builds the block with its default eight lanes and sixteen-entry program store. This is small enough that every lane is checked on every output word of every run. A diffuse-lighting program runs over three data sets whose dot products fall below 0, inside the unit range and above 1.0, so both clamp bounds and the interior are reached in different lanes at once. A second program drives the extremes of the 16-bit range through the multiply and multiply-add paths, in both signs, with register and broadcast second operands. The same program is used to check that loads and start are locked out while a run is in progress.

// File: rtl/shd_pkg.sv
package shd_pkg;
  localparam int DW       = 16;
  localparam int FRAC     = 8;
  localparam int NREG     = 16;
  localparam int RAW      = $clog2(NREG);
  localparam int NCONST   = 8;
  localparam int CAW      = $clog2(NCONST);
  localparam int NOUT     = 4;
  localparam int OUT_BASE = NREG - NOUT;

  localparam logic [DW-1:0] Q_ONE = {{(DW-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MAD  = 2'd1,
    OP_CLMP = 2'd2,
    OP_MOVI = 2'd3
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [RAW-1:0]  dst;
    logic [RAW-1:0]  sa;
    logic [RAW-1:0]  sb;
    logic            cf;
    logic [DW-1:0]   imm;
  } instr_t;

  localparam int IW = $bits(instr_t);

  // Saturate a wide signed value into the DW-bit signed range.
  function automatic logic [DW-1:0] sat_q(input logic signed [2*DW:0] v);
    logic signed [2*DW:0] hi;
    logic signed [2*DW:0] lo;
    hi = {{(DW+2){1'b0}}, {(DW-1){1'b1}}};
    lo = {{(DW+2){1'b1}}, {(DW-1){1'b0}}};
    if (v > hi)      return {1'b0, {(DW-1){1'b1}}};
    else if (v < lo) return {1'b1, {(DW-1){1'b0}}};
    else             return v[DW-1:0];
  endfunction

  // Full product shifted down by FRAC (arithmetic shift floors).
  function automatic logic signed [2*DW:0] prod_q(input logic [DW-1:0] a,
                                                  input logic [DW-1:0] b);
    logic signed [2*DW:0] ae;
    logic signed [2*DW:0] be;
    logic signed [2*DW:0] p;
    ae = {{(DW+1){a[DW-1]}}, a};
    be = {{(DW+1){b[DW-1]}}, b};
    p  = ae * be;
    return p >>> FRAC;
  endfunction

  function automatic logic [DW-1:0] mul_q(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    return sat_q(prod_q(a, b));
  endfunction

  function automatic logic [DW-1:0] mad_q(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic [DW-1:0] c);
    logic signed [2*DW:0] ce;
    ce = {{(DW+1){c[DW-1]}}, c};
    return sat_q(prod_q(a, b) + ce);
  endfunction

  function automatic logic [DW-1:0] clamp_q(input logic [DW-1:0] a);
    if (a[DW-1])          return '0;
    else if (a > Q_ONE)   return Q_ONE;
    else                  return a;
  endfunction
endpackage

// File: rtl/shd_seq.sv
module shd_seq
  import shd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] run_len,
  input  logic          im_we,
  input  logic [PW-1:0] im_addr,
  input  logic [IW-1:0] im_data,
  output logic          busy,
  output logic          done,
  output logic          issue_valid,
  output instr_t        issue
);
  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] pc;
  logic [LW-1:0] last_q;
  logic          accept;
  logic          at_last;

  assign accept  = start && !busy && (run_len != '0) && (run_len <= LW'(DEPTH));
  assign at_last = ({1'b0, pc} == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (im_we && !busy) begin
      mem[im_addr] <= im_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pc     <= '0;
      last_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        pc     <= '0;
        last_q <= run_len - LW'(1);
      end else if (busy) begin
        if (at_last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pc <= pc + PW'(1);
        end
      end
    end
  end

  assign issue_valid = busy;
  assign issue       = instr_t'(mem[pc]);
endmodule

// File: rtl/shd_lane.sv
module shd_lane
  import shd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctx_we,
  input  logic [RAW-1:0]     ctx_reg,
  input  logic [DW-1:0]      ctx_data,
  input  logic               issue_valid,
  input  instr_t             issue,
  input  logic [DW-1:0]      cb_val,
  output logic [DW-1:0]      wr_data,
  output logic [NOUT*DW-1:0] out_rec
);
  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opa;
  logic [DW-1:0] opb;
  logic [DW-1:0] acc;

  assign opa = rf[issue.sa];
  assign opb = issue.cf ? cb_val : rf[issue.sb];
  assign acc = rf[issue.dst];

  always_comb begin
    case (issue.op)
      OP_MUL:  wr_data = mul_q(opa, opb);
      OP_MAD:  wr_data = mad_q(opa, opb, acc);
      OP_CLMP: wr_data = clamp_q(opa);
      default: wr_data = issue.imm;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (issue_valid) begin
      rf[issue.dst] <= wr_data;
    end else if (ctx_we) begin
      rf[ctx_reg] <= ctx_data;
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign out_rec[k*DW +: DW] = rf[OUT_BASE + k];
  end
endmodule

// File: rtl/shd_simd8_core.sv
module shd_simd8_core
  import shd_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int IMEM_DEPTH = 16,
  localparam int LNW = $clog2(LANES),
  localparam int PW  = $clog2(IMEM_DEPTH),
  localparam int LW  = PW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LW-1:0]             run_len,
  input  logic                      im_we,
  input  logic [PW-1:0]             im_addr,
  input  logic [IW-1:0]             im_data,
  input  logic                      cb_we,
  input  logic [CAW-1:0]            cb_addr,
  input  logic [DW-1:0]             cb_data,
  input  logic                      ctx_we,
  input  logic [LNW-1:0]            ctx_lane,
  input  logic [RAW-1:0]            ctx_reg,
  input  logic [DW-1:0]             ctx_data,
  output logic                      busy,
  output logic                      done,
  output logic [LANES*NOUT*DW-1:0]  out_rec
);
  instr_t              issue;
  logic                issue_valid;
  logic [DW-1:0]       cbank [NCONST];
  logic [DW-1:0]       cb_val;
  logic [1:0]          issue_op_w;
  logic [DW-1:0]       issue_imm_w;
  logic [LANES*DW-1:0] lane_wdata_w;

  shd_seq #(.DEPTH(IMEM_DEPTH)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .run_len     (run_len),
    .im_we       (im_we),
    .im_addr     (im_addr),
    .im_data     (im_data),
    .busy        (busy),
    .done        (done),
    .issue_valid (issue_valid),
    .issue       (issue)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCONST; i++) cbank[i] <= '0;
    end else if (cb_we && !busy) begin
      cbank[cb_addr] <= cb_data;
    end
  end

  // One read of the bank, broadcast to every lane.
  assign cb_val      = cbank[issue.sb[CAW-1:0]];
  assign issue_op_w  = issue.op;
  assign issue_imm_w = issue.imm;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_ctx_we;
    assign lane_ctx_we = ctx_we && !busy && (ctx_lane == LNW'(l));
    shd_lane lane_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctx_we      (lane_ctx_we),
      .ctx_reg     (ctx_reg),
      .ctx_data    (ctx_data),
      .issue_valid (issue_valid),
      .issue       (issue),
      .cb_val      (cb_val),
      .wr_data     (lane_wdata_w[l*DW +: DW]),
      .out_rec     (out_rec[l*NOUT*DW +: NOUT*DW])
    );
  end
endmodule

// File: rtl/shd_simd8_core_chk.sv
module shd_simd8_core_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 16,
  parameter int LW    = 5,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [LW-1:0]       run_len,
  input logic                busy,
  input logic                done,
  input logic                issue_valid,
  input logic [1:0]          issue_op,
  input logic [DW-1:0]       issue_imm,
  input logic [LANES*DW-1:0] lane_wdata
);
  // R2: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: done follows the final busy cycle
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2: a valid start while idle begins a run
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && run_len != '0 && run_len <= LW'(DEPTH)) |=> busy);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    // R5: clamp result stays inside [0, 1.0]
    assert_clamp_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 2'd2) |->
        (!lane_wdata[l*DW + DW-1] && lane_wdata[l*DW +: DW] <= DW'(256)));

    // R6: literal move gives the same literal in every lane
    assert_movi_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_op == 2'd3) |->
        (lane_wdata[l*DW +: DW] == issue_imm && lane_wdata[l*DW +: DW] == lane_wdata[DW-1:0]));
  end
endmodule

bind shd_simd8_core shd_simd8_core_chk #(
  .LANES (LANES),
  .DEPTH (IMEM_DEPTH),
  .LW    (LW),
  .DW    (shd_pkg::DW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .run_len     (run_len),
  .busy        (busy),
  .done        (done),
  .issue_valid (issue_valid),
  .issue_op    (issue_op_w),
  .issue_imm   (issue_imm_w),
  .lane_wdata  (lane_wdata_w)
);

// File: tb/shd_simd8_core_tb_top.sv
module shd_simd8_core_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [4:0]   run_len = '0;
  logic         im_we = 1'b0;
  logic [3:0]   im_addr = '0;
  logic [30:0]  im_data = '0;
  logic         cb_we = 1'b0;
  logic [2:0]   cb_addr = '0;
  logic [15:0]  cb_data = '0;
  logic         ctx_we = 1'b0;
  logic [2:0]   ctx_lane = '0;
  logic [3:0]   ctx_reg = '0;
  logic [15:0]  ctx_data = '0;
  logic         busy;
  logic         done;
  logic [511:0] out_rec;

  int n_checks = 0;
  int n_fails  = 0;

  int m [8][16];
  int cbm [8];
  int p_op [16];
  int p_dst [16];
  int p_a [16];
  int p_b [16];
  int p_cf [16];
  int p_imm [16];

  always #2 clk = ~clk;

  shd_simd8_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .im_we(im_we), .im_addr(im_addr), .im_data(im_data),
    .cb_we(cb_we), .cb_addr(cb_addr), .cb_data(cb_data),
    .ctx_we(ctx_we), .ctx_lane(ctx_lane), .ctx_reg(ctx_reg), .ctx_data(ctx_data),
    .busy(busy), .done(done), .out_rec(out_rec)
  );

  function automatic int sx(int v);
    int t;
    t = v & 32'hFFFF;
    if (t >= 32768) t = t - 65536;
    return t;
  endfunction

  function automatic int fdiv(int p);
    if (p >= 0) return p / 256;
    return -((-p + 255) / 256);
  endfunction

  function automatic int bsat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic chk(string req, string what, int got, int expv);
    n_checks++;
    if (got != expv) begin
      n_fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  task automatic ld_ctx(int l, int r, int v);
    ctx_we = 1'b1; ctx_lane = 3'(l); ctx_reg = 4'(r); ctx_data = 16'(v);
    @(negedge clk);
    ctx_we = 1'b0;
    m[l][r] = sx(v);
  endtask

  task automatic ld_cb(int i, int v);
    cb_we = 1'b1; cb_addr = 3'(i); cb_data = 16'(v);
    @(negedge clk);
    cb_we = 1'b0;
    cbm[i] = sx(v);
  endtask

  // R8: op [30:29], dst [28:25], sa [24:21], sb [20:17], flag [16], literal [15:0]
  task automatic emit(int i, int op, int dst, int a, int b, int cf, int imm);
    p_op[i] = op; p_dst[i] = dst; p_a[i] = a; p_b[i] = b; p_cf[i] = cf; p_imm[i] = imm;
    im_we = 1'b1; im_addr = 4'(i);
    im_data = {2'(op), 4'(dst), 4'(a), 4'(b), 1'(cf), 16'(imm)};
    @(negedge clk);
    im_we = 1'b0;
  endtask

  task automatic model_run(int len);
    for (int l = 0; l < 8; l++) begin
      for (int i = 0; i < len; i++) begin
        int a, b, r;
        a = m[l][p_a[i]];
        b = (p_cf[i] != 0) ? cbm[p_b[i] % 8] : m[l][p_b[i]];
        case (p_op[i])
          0: r = bsat(fdiv(a * b));
          1: r = bsat(fdiv(a * b) + m[l][p_dst[i]]);
          2: r = (a < 0) ? 0 : ((a > 256) ? 256 : a);
          default: r = sx(p_imm[i]);
        endcase
        m[l][p_dst[i]] = r;
      end
    end
  endtask

  // R2 timing; with poke set, R10 lockout stimulus is applied mid-run
  task automatic run(int len, bit poke);
    int cnt;
    start = 1'b1; run_len = 5'(len);
    @(negedge clk);
    start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    if (poke) begin
      start = 1'b1; run_len = 5'(len);
      ctx_we = 1'b1; ctx_lane = 3'd5; ctx_reg = 4'd14; ctx_data = 16'h1234;
      cb_we = 1'b1; cb_addr = 3'd3; cb_data = 16'h0100;
      im_we = 1'b1; im_addr = 4'd0; im_data = '0;
    end
    cnt = 1;
    while (!done && cnt < 1000) begin
      @(negedge clk);
      start = 1'b0; ctx_we = 1'b0; cb_we = 1'b0; im_we = 1'b0;
      cnt++;
    end
    chk("R2", "cycles to done", cnt, len + 1);
    chk("R2", "busy low at done", int'(busy), 0);
    model_run(len);
  endtask

  task automatic check_out(string req);
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 4; k++)
        chk(req, $sformatf("lane %0d out %0d", l, k),
            int'(out_rec[(l*4+k)*16 +: 16]), m[l][12+k] & 32'hFFFF);
  endtask

  initial begin
    #800000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int l = 0; l < 8; l++) for (int r = 0; r < 16; r++) m[l][r] = 0;
    for (int i = 0; i < 8; i++) cbm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "out_rec zero", int'(out_rec == '0), 1);

    // Diffuse program: R3 R4 R5 R6 R7 R9 R11
    emit(0, 0, 3, 4, 0, 1, 0);
    emit(1, 1, 3, 5, 1, 1, 0);
    emit(2, 1, 3, 6, 2, 1, 0);
    emit(3, 2, 3, 3, 0, 0, 0);
    emit(4, 0, 12, 0, 3, 0, 0);
    emit(5, 0, 13, 1, 3, 0, 0);
    emit(6, 0, 14, 2, 3, 0, 0);
    emit(7, 3, 15, 0, 0, 0, 256);
    for (int s = 0; s < 3; s++) begin
      int c0, c1, c2;
      c0 = (s == 0) ? 148 : (s == 1) ? -181 : 256;
      c1 = (s == 0) ? 148 : (s == 1) ? 0    : -256;
      c2 = (s == 0) ? 148 : (s == 1) ? 181  : 90;
      ld_cb(0, c0); ld_cb(1, c1); ld_cb(2, c2);
      for (int l = 0; l < 8; l++) begin
        ld_ctx(l, 0, (l*45 + s*70) % 300);
        ld_ctx(l, 1, 256 - l*20 - s*9);
        ld_ctx(l, 2, (l*l*7 + s*33) % 260);
        ld_ctx(l, 4, ((l*97 + s*51) % 700) - 350);
        ld_ctx(l, 5, ((l*61 + s*23) % 600) - 300);
        ld_ctx(l, 6, 200 - l*50 + s*17);
      end
      run(8, 1'b0);
      check_out("R11 R5 R9");
    end

    // Saturation program: R3 R4 R7, then R10 lockout
    emit(0, 0, 12, 0, 1, 0, 0);
    emit(1, 0, 13, 0, 3, 1, 0);
    emit(2, 2, 15, 1, 0, 0, 0);
    emit(3, 1, 13, 1, 3, 1, 0);
    for (int s = 0; s < 2; s++) begin
      int va [8];
      int vb [8];
      va = '{32'h7FFF, 32'h8000, 32'h0100, 32'hFE80, 32'h4000, 32'h0001, 32'hC000, 32'h0033};
      vb = '{32'h7FFF, 32'h7FFF, 32'h0180, 32'h0200, 32'hFF00, 32'hFFFF, 32'hC000, 32'h8000};
      ld_cb(3, (s == 0) ? 32'h7000 : 32'hFF00);
      for (int l = 0; l < 8; l++) begin
        ld_ctx(l, 0, va[l]);
        ld_ctx(l, 1, vb[l]);
        ld_ctx(l, 14, l*3 + s);
      end
      run(4, s == 1);
      check_out((s == 0) ? "R3 R4 R7" : "R10 R3 R4");
    end
    // R10: the start issued mid-run must not begin another run
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "no extra run busy", int'(busy), 0);
      chk("R10", "no extra done", int'(done), 0);
    end
    // R10: program word 0 untouched (MUL r12 = r0*r1 again)
    run(4, 1'b0);
    check_out("R10 program kept");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule